// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the per-channel transfer registers of a four-channel DMA controller. Each channel has a base address, a base word count, a current address and a progress count. Software reaches all sixteen-bit registers through an eight-bit port. A single shared byte pointer selects whether an access touches the low byte or the high byte. The pointer toggles after every register access and can be forced back to the low byte with a clear strobe.

Writing the high byte of either base register starts a new transfer set-up for that channel. The current address is reloaded from the base address, shifted by the width parameter, and the progress count goes to zero. The transfer engine reports progress through a plain strobe with a channel number and a position. Read-back shows live progress. The count reads as the scaled base count minus progress. The address reads as the current address plus or minus progress, depending on the channel's direction input.

A separate page port holds a page byte and a high-page byte for each channel. These are combined with the current address into a 32-bit physical address for every channel. The `SHIFT` parameter is 0 for a byte-transfer controller and 1 for a word-transfer controller. All ports are plain strobes, because none of them carries a data stream.

Top module: `dma_chan_regfile`

## Requirements
- R1: After synchronous reset, all base, current, progress and page registers and the byte pointer are zero, so every read returns 0x00 and every physical address is 0.
- R2: A channel-port write stores the data byte in the low byte of the selected base register when the pointer is 0, and in the high byte when it is 1. Every channel read or write toggles the pointer. Port index is `reg_addr >> SHIFT`: bits 2:1 give the channel, and bit 0 selects address (0) or count (1).
- R3: A high-byte write to either base register of a channel loads that channel's current address with `base_address << SHIFT` and clears its progress count. A low-byte write leaves the current address unchanged.
- R4: Count read-back value is `(base_count << SHIFT) - progress`, taken modulo the current-register width.
- R5: Address read-back value is `current_address + progress` when the channel's `dir_down` bit is 0, and `current_address - progress` when it is 1.
- R6: The byte returned on a channel read is `(value >> (SHIFT + 8*pointer)) & 0xFF`. It is valid in the same cycle as `chan_rd`.
- R7: `ptr_clr` forces the pointer to 0 on the next edge and takes priority over a toggle in the same cycle.
- R8: Page offsets map to channels as 1→2, 2→3, 3→1 and 7→0, for both the page and the high-page registers, and each reads back the byte written.
- R9: Page or high-page accesses at offsets 0, 4, 5 and 6 read 0x00 and change no state.
- R10: Channel physical address is `((high_page & 0x7F) << 24) | (page << 16) | current_address`.
- R11: `prog_we` loads the progress count of channel `prog_chan`. A high-byte write to the same channel in the same cycle takes priority and leaves the progress count at zero.
- R12: With `SHIFT = 1`, the address decode, the current-address reload and the read-back byte selection all apply the one-bit scaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3+SHIFT | Channel-port address |
| page_off | input | 3 | Page-port offset |
| wdata | input | 8 | Write data byte |
| chan_wr | input | 1 | Channel register write strobe |
| chan_rd | input | 1 | Channel register read strobe |
| page_wr | input | 1 | Page register write strobe |
| page_rd | input | 1 | Page register read strobe |
| hpage_wr | input | 1 | High-page register write strobe |
| hpage_rd | input | 1 | High-page register read strobe |
| ptr_clr | input | 1 | Byte pointer clear |
| dir_down | input | 4 | Per-channel direction: 1 means address counts down |
| prog_we | input | 1 | Progress update strobe |
| prog_chan | input | 2 | Channel of the progress update |
| prog_val | input | 16+SHIFT | New progress count |
| rdata | output | 8 | Read data byte, combinational |
| phys_addr | output | 128 | Four 32-bit physical addresses, channel 0 in the low bits |

## Verification
The assertions assume that at most one of the six access strobes is high in any cycle, and they check this. The expected read-back values assume that `dir_down` and the progress count stay steady while a two-byte read is in progress. The bench drives one strobe per task cycle and only changes direction or progress between complete byte-pair accesses. A dedicated task drives a progress update together with a high-byte write, so that the case where both hit the same channel is exercised.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int NCH   = 4;
  localparam int CH_W  = $clog2(NCH);
  localparam int PA_W  = 32;

  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic            ok;
    logic [CH_W-1:0] ch;
  } page_slot_t;

  // Fixed page-offset to channel mapping; unlisted offsets are invalid.
  function automatic page_slot_t page_slot(input logic [2:0] off);
    page_slot_t s;
    s = '0;
    unique case (off)
      3'd1: s = '{ok: 1'b1, ch: 2'd2};
      3'd2: s = '{ok: 1'b1, ch: 2'd3};
      3'd3: s = '{ok: 1'b1, ch: 2'd1};
      3'd7: s = '{ok: 1'b1, ch: 2'd0};
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic access,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= 1'b0;
    else if (access) ptr <= ~ptr;
  end

  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (access && !clr) |=> (ptr != $past(ptr)));

  // R7
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == 1'b0));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int SHIFT = 0,
  localparam int CUR_W = 16 + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_cnt,
  input  logic             ptr,
  input  logic [7:0]       wdata,
  input  logic             prog_we,
  input  logic [CUR_W-1:0] prog_val,
  input  logic             dir_down,
  output logic [CUR_W-1:0] addr_val,
  output logic [CUR_W-1:0] cnt_val,
  output logic [CUR_W-1:0] cur_addr
);
  logic [15:0]      base_addr, base_cnt;
  logic [15:0]      nxt_addr, nxt_cnt;
  logic [CUR_W-1:0] prog;
  logic             hi_wr, lo_wr;

  assign hi_wr = wr_en &  ptr;
  assign lo_wr = wr_en & ~ptr;

  always_comb begin
    nxt_addr = base_addr;
    nxt_cnt  = base_cnt;
    if (wr_en) begin
      if (wr_cnt) begin
        if (ptr) nxt_cnt[15:8] = wdata;
        else     nxt_cnt[7:0]  = wdata;
      end else begin
        if (ptr) nxt_addr[15:8] = wdata;
        else     nxt_addr[7:0]  = wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      prog      <= '0;
    end else begin
      base_addr <= nxt_addr;
      base_cnt  <= nxt_cnt;
      if (hi_wr) begin
        cur_addr <= CUR_W'(nxt_addr) << SHIFT;
        prog     <= '0;
      end else if (prog_we) begin
        prog <= prog_val;
      end
    end
  end

  assign addr_val = dir_down ? (cur_addr - prog) : (cur_addr + prog);
  assign cnt_val  = (CUR_W'(base_cnt) << SHIFT) - prog;

  // R3
  reload_clears_prog_chk: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> (prog == '0));

  // R3
  low_write_keeps_cur_chk: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> $stable(cur_addr));
endmodule

// File: rtl/dma_page_regs.sv
module dma_page_regs
  import dma_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           off,
  input  logic [7:0]           wdata,
  input  logic                 page_wr,
  input  logic                 hpage_wr,
  output logic [NCH-1:0][7:0]  page_q,
  output logic [NCH-1:0][7:0]  hpage_q,
  output logic [7:0]           page_rd_data,
  output logic [7:0]           hpage_rd_data
);
  page_slot_t slot;
  assign slot = page_slot(off);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q  <= '0;
      hpage_q <= '0;
    end else if (slot.ok) begin
      if (page_wr)  page_q[slot.ch]  <= wdata;
      if (hpage_wr) hpage_q[slot.ch] <= wdata;
    end
  end

  assign page_rd_data  = slot.ok ? page_q[slot.ch]  : 8'h00;
  assign hpage_rd_data = slot.ok ? hpage_q[slot.ch] : 8'h00;

  // R9
  invalid_page_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    ((page_wr || hpage_wr) && !slot.ok) |=> ($stable(page_q) && $stable(hpage_q)));
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_regs_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int CUR_W = 16 + SHIFT,
  localparam int RA_W  = 3 + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [2:0]        page_off,
  input  logic [7:0]        wdata,
  input  logic              chan_wr,
  input  logic              chan_rd,
  input  logic              page_wr,
  input  logic              page_rd,
  input  logic              hpage_wr,
  input  logic              hpage_rd,
  input  logic              ptr_clr,
  input  logic [3:0]        dir_down,
  input  logic              prog_we,
  input  logic [1:0]        prog_chan,
  input  logic [CUR_W-1:0]  prog_val,
  output logic [7:0]        rdata,
  output logic [127:0]      phys_addr
);
  logic [2:0]               idx;
  logic [CH_W-1:0]          sel_ch;
  logic                     sel_cnt;
  logic                     ptr;
  logic [NCH-1:0][CUR_W-1:0] addr_val, cnt_val, cur_addr;
  logic [NCH-1:0][7:0]      page_q, hpage_q;
  logic [7:0]               page_rd_data, hpage_rd_data;
  logic [CUR_W-1:0]         rd_val;
  logic [7:0]               chan_byte;

  assign idx     = 3'(reg_addr >> SHIFT);
  assign sel_ch  = idx[2:1];
  assign sel_cnt = idx[0];

  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst    (rst),
    .clr    (ptr_clr),
    .access (chan_wr | chan_rd),
    .ptr    (ptr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan_regs #(.SHIFT(SHIFT)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (chan_wr && (sel_ch == CH_W'(i))),
      .wr_cnt   (sel_cnt),
      .ptr      (ptr),
      .wdata    (wdata),
      .prog_we  (prog_we && (prog_chan == CH_W'(i))),
      .prog_val (prog_val),
      .dir_down (dir_down[i]),
      .addr_val (addr_val[i]),
      .cnt_val  (cnt_val[i]),
      .cur_addr (cur_addr[i])
    );

    assign phys_addr[i*PA_W +: PA_W] =
      {1'b0, hpage_q[i][6:0], page_q[i], 16'h0000} | PA_W'(cur_addr[i]);
  end

  dma_page_regs u_page (
    .clk           (clk),
    .rst           (rst),
    .off           (page_off),
    .wdata         (wdata),
    .page_wr       (page_wr),
    .hpage_wr      (hpage_wr),
    .page_q        (page_q),
    .hpage_q       (hpage_q),
    .page_rd_data  (page_rd_data),
    .hpage_rd_data (hpage_rd_data)
  );

  assign rd_val    = sel_cnt ? cnt_val[sel_ch] : addr_val[sel_ch];
  assign chan_byte = ptr ? rd_val[SHIFT+8 +: 8] : rd_val[SHIFT +: 8];

  always_comb begin
    if (chan_rd)       rdata = chan_byte;
    else if (page_rd)  rdata = page_rd_data;
    else if (hpage_rd) rdata = hpage_rd_data;
    else               rdata = 8'h00;
  end

  // R2 (input rule: one access strobe per cycle)
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chan_wr, chan_rd, page_wr, page_rd, hpage_wr, hpage_rd}));
endmodule

// File: tb/sim_dma_chan_regfile.sv
module sim_dma_chan_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  reg_addr;
  logic [2:0]  page_off;
  logic [7:0]  wdata;
  logic        chan_wr, chan_rd, page_wr, page_rd, hpage_wr, hpage_rd, ptr_clr;
  logic [3:0]  dir_down;
  logic        prog_we;
  logic [1:0]  prog_chan;
  logic [16:0] prog_val;
  logic [7:0]  rdata0, rdata1;
  logic [127:0] phys0, phys1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dma_chan_regfile #(.SHIFT(0)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .page_off(page_off), .wdata(wdata),
    .chan_wr(chan_wr), .chan_rd(chan_rd), .page_wr(page_wr), .page_rd(page_rd),
    .hpage_wr(hpage_wr), .hpage_rd(hpage_rd), .ptr_clr(ptr_clr), .dir_down(dir_down),
    .prog_we(prog_we), .prog_chan(prog_chan), .prog_val(prog_val[15:0]),
    .rdata(rdata0), .phys_addr(phys0));

  dma_chan_regfile #(.SHIFT(1)) u1 (
    .clk(clk), .rst(rst), .reg_addr({reg_addr, 1'b0}), .page_off(page_off), .wdata(wdata),
    .chan_wr(chan_wr), .chan_rd(chan_rd), .page_wr(page_wr), .page_rd(page_rd),
    .hpage_wr(hpage_wr), .hpage_rd(hpage_rd), .ptr_clr(ptr_clr), .dir_down(dir_down),
    .prog_we(prog_we), .prog_chan(prog_chan), .prog_val(prog_val),
    .rdata(rdata1), .phys_addr(phys1));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_all();
    chan_wr = 0; chan_rd = 0; page_wr = 0; page_rd = 0; hpage_wr = 0; hpage_rd = 0;
    ptr_clr = 0; prog_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_all(); rst = 1; reg_addr = 0; page_off = 0; wdata = 0;
    dir_down = 0; prog_chan = 0; prog_val = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic wr_chan(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; wdata = d; chan_wr = 1;
    @(negedge clk); chan_wr = 0;
  endtask

  task automatic rd_chan(input logic [2:0] a, output logic [7:0] d0, output logic [7:0] d1);
    @(negedge clk); reg_addr = a; chan_rd = 1;
    #1; d0 = rdata0; d1 = rdata1;
    @(negedge clk); chan_rd = 0;
  endtask

  task automatic clr_ptr();
    @(negedge clk); ptr_clr = 1;
    @(negedge clk); ptr_clr = 0;
  endtask

  task automatic set_prog(input logic [1:0] ch, input logic [16:0] v);
    @(negedge clk); prog_chan = ch; prog_val = v; prog_we = 1;
    @(negedge clk); prog_we = 0;
  endtask

  task automatic wr_page(input bit high, input logic [2:0] off, input logic [7:0] d);
    @(negedge clk); page_off = off; wdata = d;
    if (high) hpage_wr = 1; else page_wr = 1;
    @(negedge clk); page_wr = 0; hpage_wr = 0;
  endtask

  task automatic rd_page(input bit high, input logic [2:0] off, output logic [7:0] d);
    @(negedge clk); page_off = off;
    if (high) hpage_rd = 1; else page_rd = 1;
    #1; d = rdata0;
    @(negedge clk); page_rd = 0; hpage_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] a, b;
    do_reset();
    rd_chan(3'd2, a, b); check("R1 addr lo after reset", a, 8'h00);
    rd_chan(3'd2, a, b); check("R1 addr hi after reset", a, 8'h00);
    check("R1 phys after reset", phys0[63:32], 32'h0);
    rd_page(0, 3'd1, a); check("R1 page after reset", a, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] a, b;
    clr_ptr();
    wr_chan(3'd2, 8'h34);
    check("R3 low byte write keeps current", phys0[63:32], 32'h0);
    wr_chan(3'd2, 8'h12);
    check("R3 high byte write reloads current", phys0[63:32], 32'h0000_1234);
    rd_chan(3'd2, a, b); check("R2 R6 addr low byte", a, 8'h34);
    rd_chan(3'd2, a, b); check("R2 R6 addr high byte", a, 8'h12);
  endtask

  task automatic t_progress();
    logic [7:0] a, b;
    wr_chan(3'd3, 8'h10);
    wr_chan(3'd3, 8'h00);
    set_prog(2'd1, 17'd4);
    rd_chan(3'd3, a, b); check("R4 count lo", a, 8'h0C);
    rd_chan(3'd3, a, b); check("R4 count hi", a, 8'h00);
    rd_chan(3'd2, a, b); check("R5 R11 addr up lo", a, 8'h38);
    rd_chan(3'd2, a, b); check("R5 addr up hi", a, 8'h12);
    @(negedge clk); dir_down = 4'b0010;
    rd_chan(3'd2, a, b); check("R5 addr down lo", a, 8'h30);
    rd_chan(3'd2, a, b); check("R5 addr down hi", a, 8'h12);
    set_prog(2'd1, 17'h40);
    rd_chan(3'd2, a, b); check("R5 addr down borrow lo", a, 8'hF4);
    rd_chan(3'd2, a, b); check("R5 addr down borrow hi", a, 8'h11);
    @(negedge clk); dir_down = 4'b0000;
  endtask

  task automatic t_ptr_clear();
    logic [7:0] a, b;
    wr_chan(3'd4, 8'hAA);
    clr_ptr();
    rd_chan(3'd2, a, b); check("R7 clear returns to low byte", a, 8'h74);
    // read and clear in same cycle: clear wins
    @(negedge clk); reg_addr = 3'd2; chan_rd = 1; ptr_clr = 1;
    @(negedge clk); chan_rd = 0; ptr_clr = 0;
    rd_chan(3'd2, a, b); check("R7 clear beats toggle", a, 8'h74);
    clr_ptr();
  endtask

  task automatic t_reload_priority();
    logic [7:0] a, b;
    set_prog(2'd1, 17'd4);
    wr_chan(3'd3, 8'h10);
    @(negedge clk); reg_addr = 3'd3; wdata = 8'h00; chan_wr = 1;
    prog_we = 1; prog_chan = 2'd1; prog_val = 17'd8;
    @(negedge clk); chan_wr = 0; prog_we = 0;
    rd_chan(3'd3, a, b); check("R11 reload beats progress lo", a, 8'h10);
    rd_chan(3'd3, a, b); check("R11 reload beats progress hi", a, 8'h00);
  endtask

  task automatic t_pages();
    logic [7:0] a;
    wr_page(0, 3'd1, 8'hAB);
    wr_page(1, 3'd1, 8'hFF);
    check("R8 R10 phys ch2", phys0[95:64], 32'h7FAB_0000);
    wr_page(0, 3'd7, 8'h5C);
    rd_page(0, 3'd7, a); check("R8 offset 7 page", a, 8'h5C);
    check("R8 R10 phys ch0", phys0[31:0], 32'h005C_0000);
    wr_page(0, 3'd3, 8'h01);
    check("R8 R10 phys ch1", phys0[63:32], 32'h0001_1234);
    wr_page(1, 3'd2, 8'h80);
    rd_page(1, 3'd2, a); check("R8 offset 2 high page", a, 8'h80);
    check("R10 high page bit 7 masked", phys0[127:96], 32'h0);
  endtask

  task automatic t_invalid_pages();
    logic [7:0] a;
    for (int k = 0; k < 7; k++) begin
      if (k == 0 || k >= 4) begin
        wr_page(0, 3'(k), 8'h55);
        wr_page(1, 3'(k), 8'h66);
        rd_page(0, 3'(k), a); check("R9 invalid page reads zero", a, 8'h00);
        rd_page(1, 3'(k), a); check("R9 invalid high page reads zero", a, 8'h00);
      end
    end
    check("R9 ch0 unchanged", phys0[31:0], 32'h005C_0000);
    check("R9 ch1 unchanged", phys0[63:32], 32'h0001_1234);
    check("R9 ch2 unchanged", phys0[95:64], 32'h7FAB_0000);
    check("R9 ch3 unchanged", phys0[127:96], 32'h0);
  endtask

  task automatic t_word_shift();
    logic [7:0] a, b;
    do_reset();
    wr_chan(3'd0, 8'h34);
    wr_chan(3'd0, 8'h12);
    check("R12 word current address", phys1[31:0], 32'h0000_2468);
    wr_chan(3'd1, 8'h10);
    wr_chan(3'd1, 8'h00);
    set_prog(2'd0, 17'd4);
    rd_chan(3'd0, a, b);
    check("R12 word addr lo", b, 8'h36);
    check("R6 byte addr lo", a, 8'h38);
    rd_chan(3'd0, a, b); check("R12 word addr hi", b, 8'h12);
    rd_chan(3'd1, a, b);
    check("R12 word count lo", b, 8'h0E);
    check("R4 byte count lo", a, 8'h0C);
    rd_chan(3'd1, a, b); check("R12 word count hi", b, 8'h00);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1;
    idle_all();
    t_reset();
    t_write_read();
    t_progress();
    t_ptr_clear();
    t_reload_priority();
    t_pages();
    t_invalid_pages();
    t_word_shift();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule